// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Status

This block holds two 8-bit up-counting interval timers with an interrupt status byte, in the style of the timer section of a classic FM tone generator. A shared prescaler derives a fast tick from the system clock. The nominal period of the fast tick is 80 µs. A second tick, four times slower (320 µs nominal), drives the other timer. Each timer counts up from a host-written preload value. When the count passes 0xFF the timer overflows, reloads from its preload and keeps running. Software that wants N ticks therefore writes 256 − N as the preload.

The host reaches the block through two write strobes. An index strobe captures a register number from the data bus. A data strobe then writes the selected register. The block has three registers: one preload per timer and a shared control register. The control register carries a start bit and a mask bit for each timer, plus an interrupt-clear bit. The status byte is always visible on an output port. It carries a summary flag, one overflow flag per timer and a fixed identification pattern in the low bits. A driver can use that pattern, together with a timed overflow test, to confirm that the block is present.

Top module: `fm_timer_pair`

## Requirements
- R1: After reset, the status byte reads 0x06 (summary and both flags clear, identification bits at their default) and `irq` is low. Both timers are stopped and unmasked.
- R2: Set timer 1's preload to 0xFF, then write control 0x21 (timer 2 masked, timer 1 started). Status bits 7..5 then read binary 110 no later than one fast-tick period (plus a few clocks of latency) after the write.
- R3: With preload P, timer 1 overflows every (256 − P) fast ticks, and one fast tick lasts CLK_HZ × TICK_NS / 10^9 clocks.
- R4: Timer 2 works the same way on a tick that is T2_RATIO (default 4) fast ticks long. Its overflow flag is status bit 5.
- R5: On overflow, a running timer reloads from its preload and keeps counting, so successive overflows are evenly spaced.
- R6: While its mask bit is set, a timer never sets its flag, never sets status bit 7 and never raises `irq`.
- R7: Writing the control register with bit 7 set clears status bits 7..5 and drops `irq`. It leaves the mask and start bits unchanged. If a clear and an overflow land in the same cycle, the clear wins.
- R8: While its start bit is clear, a timer does not advance and never flags. Setting the start bit when it was clear loads the counter from its preload.
- R9: Status bits 4..0 always read the parameter SIG (default 5'b00110) and never change.
- R10: `irq` always equals status bit 7.
- R11: An index strobe latches `wdata` as the register index. Index 2 selects the timer 1 preload, index 3 the timer 2 preload and index 4 the control register. A data strobe writes only the selected register, and a data strobe to any other index changes nothing.
- R12: Status bit 7 is set exactly when bit 6 or bit 5 is set. Control bit 6 masks timer 1, bit 5 masks timer 2, bit 0 starts timer 1 and bit 1 starts timer 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wr | input | 1 | Index strobe: latch `wdata` as register index |
| data_wr | input | 1 | Data strobe: write `wdata` to the indexed register |
| wdata | input | 8 | Host write data |
| status | output | 8 | Registered status byte (summary, flags, identification bits) |
| irq | output | 1 | Registered interrupt request, high while any unmasked flag is set |

## Verification
The timers are run with the single-tick preload 0xFF, with a five-tick preload on timer 1 and with a two-tick preload on timer 2. The time between two overflows, with a clear in between, is measured exactly. This separates a wrong tick base, a wrong tick ratio, a missing reload and an off-by-one count. Runs with the timer masked but running, and with it unmasked but stopped, separate the mask path from the start path. Writes to an unused index and to the other timer's preload, followed by a timed overflow, show whether the index decode reaches only the selected register.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int NUM_TMR = 2;

  // control register layout
  localparam int CTL_IRQ_CLR  = 7;
  localparam int CTL_MASK_TOP = 6;   // timer i mask at bit CTL_MASK_TOP - i
  // timer i start at bit i

  typedef struct packed {
    logic [NUM_TMR-1:0] mask;
    logic [NUM_TMR-1:0] run;
  } ctl_t;
endpackage

// File: rtl/fmt_prescaler.sv
module fmt_prescaler #(
  parameter int CYC_BASE = 10000,
  parameter int RATIO    = 4
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] tick
);
  localparam int BW = (CYC_BASE > 1) ? $clog2(CYC_BASE) : 1;
  localparam int RW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [BW-1:0] base_q;
  logic [RW-1:0] ratio_q;
  logic          base_end;

  assign base_end = (base_q == BW'(CYC_BASE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      ratio_q <= '0;
      tick    <= '0;
    end else begin
      tick <= '0;
      if (base_end) begin
        base_q  <= '0;
        tick[0] <= 1'b1;
        if (ratio_q == RW'(RATIO - 1)) begin
          ratio_q <= '0;
          tick[1] <= 1'b1;
        end else begin
          ratio_q <= ratio_q + 1'b1;
        end
      end else begin
        base_q <= base_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmt_counter.sv
module fmt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] preload,
  output logic         ovf
);
  logic [W-1:0] cnt_q;

  assign ovf = tick && run && !load && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= preload;
    end else if (tick && run) begin
      if (cnt_q == {W{1'b1}}) cnt_q <= preload;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fmt_regif.sv
module fmt_regif import fmt_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int PRE_BASE = 2,
  parameter int CTL_ADDR = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           addr_wr,
  input  logic                           data_wr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_TMR-1:0][DATA_W-1:0] preload,
  output ctl_t                           ctl,
  output logic [NUM_TMR-1:0]             load,
  output logic                           irq_clr
);
  logic [DATA_W-1:0] idx_q;
  logic              ctl_hit;
  logic              ctl_wr;

  assign ctl_hit = data_wr && (idx_q == DATA_W'(CTL_ADDR));
  assign irq_clr = ctl_hit && wdata[CTL_IRQ_CLR];
  assign ctl_wr  = ctl_hit && !wdata[CTL_IRQ_CLR];

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (addr_wr) idx_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preload <= '0;
    end else if (data_wr) begin
      for (int i = 0; i < NUM_TMR; i++)
        if (idx_q == DATA_W'(PRE_BASE + i)) preload[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      load <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        load[i] <= ctl_wr && wdata[i] && !ctl.run[i];
        if (ctl_wr) begin
          ctl.mask[i] <= wdata[CTL_MASK_TOP - i];
          ctl.run[i]  <= wdata[i];
        end
      end
    end
  end
endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair import fmt_pkg::*; #(
  parameter int         CLK_HZ   = 125_000_000,
  parameter int         TICK_NS  = 80_000,
  parameter int         T2_RATIO = 4,
  parameter logic [4:0] SIG      = 5'b00110
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] status,
  output logic       irq
);
  localparam int DATA_W   = 8;
  localparam int CYC_BASE = int'((longint'(CLK_HZ) * longint'(TICK_NS)) / 64'd1_000_000_000);

  logic [1:0]                     tick;
  logic [NUM_TMR-1:0][DATA_W-1:0] preload;
  ctl_t                           ctl;
  logic [NUM_TMR-1:0]             load;
  logic [NUM_TMR-1:0]             ovf;
  logic [NUM_TMR-1:0]             flag_q;
  logic [NUM_TMR-1:0]             tmr_mask;
  logic [NUM_TMR-1:0]             tmr_run;
  logic                           irq_clr;
  logic [DATA_W-1:0]              status_d;

  assign tmr_mask = ctl.mask;
  assign tmr_run  = ctl.run;

  fmt_prescaler #(.CYC_BASE(CYC_BASE), .RATIO(T2_RATIO)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  fmt_regif #(.DATA_W(DATA_W)) u_regif (
    .clk    (clk),
    .rst    (rst),
    .addr_wr(addr_wr),
    .data_wr(data_wr),
    .wdata  (wdata),
    .preload(preload),
    .ctl    (ctl),
    .load   (load),
    .irq_clr(irq_clr)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    fmt_counter #(.W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick[g]),
      .run    (ctl.run[g]),
      .load   (load[g]),
      .preload(preload[g]),
      .ovf    (ovf[g])
    );

    always_ff @(posedge clk) begin
      if (rst)                           flag_q[g] <= 1'b0;
      else if (irq_clr)                  flag_q[g] <= 1'b0;
      else if (ovf[g] && !ctl.mask[g])   flag_q[g] <= 1'b1;
    end
  end

  always_comb begin
    status_d           = {3'b000, SIG};
    status_d[DATA_W-1] = |flag_q;
    for (int i = 0; i < NUM_TMR; i++) status_d[DATA_W-2-i] = flag_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= {3'b000, SIG};
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |flag_q;
    end
  end
endmodule

// File: rtl/fm_timer_pair_chk.sv
module fm_timer_pair_chk #(
  parameter int         NUM_TMR = 2,
  parameter logic [4:0] SIG     = 5'b00110
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         status,
  input logic               irq,
  input logic               irq_clr,
  input logic [NUM_TMR-1:0] flag_q,
  input logic [NUM_TMR-1:0] tmr_mask,
  input logic [NUM_TMR-1:0] tmr_run
);
  p_irq_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    irq == status[7]);

  p_summary_r12: assert property (@(posedge clk) disable iff (rst)
    status[7] == (status[6] | status[5]));

  p_signature_r9: assert property (@(posedge clk) disable iff (rst)
    status[4:0] == SIG);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    irq_clr |-> ##2 (status[7:5] == 3'b000));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    p_masked_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[g]) |-> !$past(tmr_mask[g]));

    p_stopped_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[g]) |-> $past(tmr_run[g]));
  end
endmodule

bind fm_timer_pair fm_timer_pair_chk #(.NUM_TMR(fmt_pkg::NUM_TMR), .SIG(SIG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .status  (status),
  .irq     (irq),
  .irq_clr (irq_clr),
  .flag_q  (flag_q),
  .tmr_mask(tmr_mask),
  .tmr_run (tmr_run)
);

// File: tb/fm_timer_pair_bench.sv
`timescale 1ns/1ps
module fm_timer_pair_bench;
  localparam int P1 = 80;    // fast tick in clocks at CLK_HZ = 1 MHz
  localparam int P2 = 320;   // slow tick
  localparam logic [7:0] IX_PRE1 = 8'd2;
  localparam logic [7:0] IX_PRE2 = 8'd3;
  localparam logic [7:0] IX_CTL  = 8'd4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] status;
  logic       irq;

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fm_timer_pair #(.CLK_HZ(1_000_000)) u_fm_timer_pair (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .data_wr(data_wr),
    .wdata(wdata), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); addr_wr = 1'b1; wdata = idx;
    @(negedge clk); addr_wr = 1'b0; data_wr = 1'b1; wdata = val;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_rise(input int b, input int limit, output int t, output bit hit);
    hit = 1'b0; t = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (!hit && status[b]) begin hit = 1'b1; t = cyc; break; end
    end
  endtask

  task automatic quiet();
    wr(IX_CTL, 8'h60);
    wr(IX_CTL, 8'h80);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 8'h06);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_detect();
    int t0, t; bit hit;
    quiet();
    chk("R7 status 7..5 after mask+clear", status[7:5], 3'b000);
    wr(IX_PRE1, 8'hFF);
    t0 = cyc;
    wr(IX_CTL, 8'h21);
    wait_rise(6, P1 + 10, t, hit);
    chk("R2 timer1 flag within one tick", hit, 1'b1);
    chk("R2 status 7..5", status[7:5], 3'b110);
    chk("R10 irq with flag", irq, 1'b1);
    chk("R9 signature bits", status[4:0], 5'b00110);
    chk("R2 latency bound", (t - t0) <= P1 + 8, 1'b1);
  endtask

  task automatic t_period1();
    int t1, t2; bit hit;
    quiet();
    wr(IX_PRE1, 8'hFB);  // five ticks
    wr(IX_CTL, 8'h21);
    wait_rise(6, 6 * P1, t1, hit);
    chk("R3 first overflow seen", hit, 1'b1);
    wr(IX_CTL, 8'h80);
    @(negedge clk);
    chk("R7 clear drops flags", status[7:5], 3'b000);
    chk("R7 clear drops irq", irq, 1'b0);
    wait_rise(6, 6 * P1, t2, hit);
    chk("R5 reload keeps running after clear", hit, 1'b1);
    chk("R3 overflow spacing 5 fast ticks", t2 - t1, 5 * P1);
  endtask

  task automatic t_timer2();
    int t1, t2; bit hit;
    quiet();
    wr(IX_PRE2, 8'hFE);  // two slow ticks
    wr(IX_CTL, 8'h42);
    wait_rise(5, 3 * P2, t1, hit);
    chk("R4 timer2 overflow seen", hit, 1'b1);
    chk("R4 status 7..5 for timer2", status[7:5], 3'b101);
    wr(IX_CTL, 8'h80);
    wait_rise(5, 3 * P2, t2, hit);
    chk("R4 timer2 spacing 2 slow ticks", t2 - t1, 2 * P2);
  endtask

  task automatic t_mask();
    int t; bit hit;
    quiet();
    wr(IX_PRE1, 8'hFF);
    wr(IX_CTL, 8'h61);
    repeat (3 * P1) @(negedge clk);
    chk("R6 masked running timer leaves status", status[7:5], 3'b000);
    chk("R6 masked running timer leaves irq", irq, 1'b0);
    wr(IX_CTL, 8'h21);
    wait_rise(6, P1 + 10, t, hit);
    chk("R6 unmask shows timer kept running", hit, 1'b1);
  endtask

  task automatic t_stop();
    quiet();
    wr(IX_PRE1, 8'hFF);
    wr(IX_PRE2, 8'hFF);
    wr(IX_CTL, 8'h00);
    repeat (2 * P2 + 20) @(negedge clk);
    chk("R8 stopped unmasked timers never flag", status[7:5], 3'b000);
  endtask

  task automatic t_regif();
    int t; bit hit;
    quiet();
    wr(IX_PRE1, 8'hFF);
    wr(IX_CTL, 8'h00);
    wr(8'd5, 8'h21);
    repeat (3 * P1) @(negedge clk);
    chk("R11 unused index leaves control", status[7:5], 3'b000);
    wr(IX_PRE2, 8'h00);
    wr(IX_CTL, 8'h21);
    wait_rise(6, P1 + 10, t, hit);
    chk("R11 timer2 preload write left timer1 preload", hit, 1'b1);
    chk("R12 summary with flag", status[7], 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_detect();
    t_period1();
    t_timer2();
    t_mask();
    t_stop();
    t_regif();
    chk("R9 signature at end", status[4:0], 5'b00110);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule